// File: doc/BRIEF.md
# Multicast Snooping Frame Classifier

This block sits on the ingress side of a small switch and watches the first bytes of every Ethernet frame as they stream past, one byte per accepted cycle. From those bytes it picks a destination for the frame and reports it as a bitmap over the front-panel ports together with a flag that selects the internal processor port. Frames whose destination address lies in the IPv4 multicast range share one address prefix. For those frames the block reads further into the IPv4 header and splits them into two groups. Group-management (IGMP) control messages go to the processor alone. Ordinary multicast traffic goes straight to the ports whose hosts have joined the group, and the processor never sees it.

Membership is held in a small fully associative table inside the block. Each entry is keyed by the low 23 bits of the group MAC address, which is the part that the standard IP-to-MAC group mapping fills in. For example, group 239.1.1.1 becomes 01:00:5E:01:01:01. The processor fills the table through a one-cycle write strobe. The block keeps no IGMP protocol state of its own.

Top module: `mcast_snoop_classifier`

## Requirements
- R1: While reset is asserted and after it is released, `dec_valid` is 0 and every table entry is invalid, so a multicast data frame sent before any table write is flooded.
- R2: A frame whose destination does not begin with the IPv4 multicast MAC prefix gets its decision in the cycle after byte 5 (the last destination byte, counting from 0) is accepted. The bitmap then holds every port except the ingress port, and `dec_cpu` is 0. This covers unicast, broadcast and other multicast frames.
- R3: A destination counts as IPv4 multicast only when bytes 0 to 2 are 01, 00, 5E and bit 7 of byte 3 is 0. The group key is bits 6:0 of byte 3, followed by byte 4 and then byte 5.
- R4: A multicast frame is IGMP when all of the following hold: EtherType bytes 12 and 13 are 08 00; byte 14 has version 4 in bits 7:4 and a header length of at least 5 in bits 3:0; protocol byte 23 is 2. Its decision comes in the cycle after byte 23, with `dec_cpu` equal to 1 and an all-zero bitmap.
- R5: A multicast frame whose EtherType is not 08 00 is treated as data and is decided in the cycle after byte 13.
- R6: A multicast IPv4 frame whose protocol is not 2, whose header length is below 5, or whose version is not 4 is treated as data and is decided in the cycle after byte 23.
- R7: A data frame whose group key matches a valid entry gets that entry's port mask with the ingress bit cleared, and `dec_cpu` is 0.
- R8: A data frame with no matching valid entry is flooded to every port except the ingress port.
- R9: A write strobe stores valid, key and mask at the given address, and the new entry is used by decisions from the next cycle on. Writing with valid 0 removes the entry.
- R10: When several valid entries match a key, the entry with the lowest address supplies the mask.
- R11: Each frame yields at most one decision, shown as a one-cycle `dec_valid` pulse. Bytes after the deciding byte are ignored. A start-of-frame byte abandons any frame still in progress, and a frame that is cut short before its deciding byte yields no decision.
- R12: The ingress port's bit is never set in `dec_ports`. The ingress port is taken from `in_port` on the start-of-frame byte only.
- R13: Bytes count only in cycles where `in_valid` is high, so idle cycles inside a frame shift the decision later without changing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | A header byte is present on `in_data` |
| in_sof | input | 1 | The present byte is byte 0 of a new frame |
| in_data | input | 8 | Header byte |
| in_port | input | 3 | Ingress port number, sampled with the start-of-frame byte |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 4 | Table entry to write |
| tbl_valid | input | 1 | Valid bit to store |
| tbl_sfx | input | 23 | Group key to store |
| tbl_mask | input | 8 | Port mask to store |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_ports | output | 8 | Destination port bitmap, valid with `dec_valid` |
| dec_cpu | output | 1 | Send to the processor port, valid with `dec_valid` |

## Verification
The properties assume that every frame starts with a byte that has `in_sof` and `in_valid` both high. They also assume that reset is released away from a clock edge and that the table is not rewritten while a frame is waiting for its decision. The stimulus meets these assumptions: it drives every frame from a single task that raises start-of-frame on byte 0 only, and it issues table writes only between frames. The property on the one-cycle pulse also depends on frames never being decided before byte 5. That holds because the parser cannot decide before the sixth accepted byte, so a back-to-back restart cannot produce two adjacent pulses.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  localparam int GRP_KEY_W = 23;
  localparam int HDR_IDX_W = 5;

  // byte positions that drive the classification
  localparam logic [HDR_IDX_W-1:0] POS_DA_LAST = 5'd5;
  localparam logic [HDR_IDX_W-1:0] POS_ETH_HI  = 5'd12;
  localparam logic [HDR_IDX_W-1:0] POS_ETH_LO  = 5'd13;
  localparam logic [HDR_IDX_W-1:0] POS_VER_HL  = 5'd14;
  localparam logic [HDR_IDX_W-1:0] POS_PROTO   = 5'd23;

  typedef enum logic [1:0] {
    CLS_PASS = 2'd0,
    CLS_DATA = 2'd1,
    CLS_CTRL = 2'd2
  } frame_cls_e;

endpackage

// File: rtl/snoop_hdr_parser.sv
module snoop_hdr_parser
  import snoop_pkg::*;
#(
  parameter int PW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sof,
  input  logic [7:0]           in_data,
  input  logic [PW-1:0]        in_port,
  output logic                 stb_q,
  output frame_cls_e           cls_q,
  output logic [GRP_KEY_W-1:0] key_q,
  output logic [PW-1:0]        ing_q
);

  logic [HDR_IDX_W-1:0] idx_q, idx_d, cur;
  logic                 act_q, act_d, done_q, done_d;
  logic                 pfx_q, pfx_d, eth_q, eth_d, hl_q, hl_d;
  logic                 stb_d;
  frame_cls_e           cls_d;
  logic [GRP_KEY_W-1:0] key_d;
  logic [PW-1:0]        ing_d;
  logic                 start, take;

  always_comb begin
    start  = in_valid & in_sof;
    take   = in_valid & (in_sof | (act_q & ~done_q));
    cur    = start ? '0 : idx_q;
    idx_d  = idx_q;
    act_d  = act_q;
    done_d = done_q;
    pfx_d  = pfx_q;
    eth_d  = eth_q;
    hl_d   = hl_q;
    key_d  = key_q;
    ing_d  = ing_q;
    cls_d  = cls_q;
    stb_d  = 1'b0;
    if (start) begin
      ing_d  = in_port;
      done_d = 1'b0;
      eth_d  = 1'b0;
      hl_d   = 1'b0;
    end
    if (take) begin
      idx_d = cur + 5'd1;
      act_d = 1'b1;
      case (cur)
        5'd0: pfx_d = (in_data == 8'h01);
        5'd1: pfx_d = pfx_q & (in_data == 8'h00);
        5'd2: pfx_d = pfx_q & (in_data == 8'h5E);
        5'd3: begin
          pfx_d        = pfx_q & ~in_data[7];
          key_d[22:16] = in_data[6:0];
        end
        5'd4: key_d[15:8] = in_data;
        POS_DA_LAST: begin
          key_d[7:0] = in_data;
          if (!pfx_q) begin
            stb_d  = 1'b1;
            cls_d  = CLS_PASS;
            done_d = 1'b1;
          end
        end
        POS_ETH_HI: eth_d = (in_data == 8'h08);
        POS_ETH_LO: begin
          if (!(eth_q && in_data == 8'h00)) begin
            stb_d  = 1'b1;
            cls_d  = CLS_DATA;
            done_d = 1'b1;
          end
        end
        POS_VER_HL: hl_d = (in_data[7:4] == 4'd4) && (in_data[3:0] >= 4'd5);
        POS_PROTO: begin
          stb_d  = 1'b1;
          cls_d  = (hl_q && in_data == 8'd2) ? CLS_CTRL : CLS_DATA;
          done_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
      pfx_q  <= 1'b0;
      eth_q  <= 1'b0;
      hl_q   <= 1'b0;
      key_q  <= '0;
      ing_q  <= '0;
      cls_q  <= CLS_PASS;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= stb_d;
      if (take) begin
        idx_q  <= idx_d;
        act_q  <= act_d;
        done_q <= done_d;
        pfx_q  <= pfx_d;
        eth_q  <= eth_d;
        hl_q   <= hl_d;
        key_q  <= key_d;
        ing_q  <= ing_d;
        cls_q  <= cls_d;
      end
    end
  end

endmodule

// File: rtl/snoop_grp_table.sv
module snoop_grp_table
  import snoop_pkg::*;
#(
  parameter int NENTRIES = 16,
  parameter int NPORTS   = 8,
  localparam int AW      = $clog2(NENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic                 wr_valid,
  input  logic [GRP_KEY_W-1:0] wr_key,
  input  logic [NPORTS-1:0]    wr_mask,
  input  logic [GRP_KEY_W-1:0] lk_key,
  output logic                 lk_hit,
  output logic [NPORTS-1:0]    lk_mask
);

  logic [NENTRIES-1:0]  vld_q, vld_d, wsel, match;
  logic [GRP_KEY_W-1:0] key_q [NENTRIES];
  logic [NPORTS-1:0]    msk_q [NENTRIES];

  always_comb begin
    for (int i = 0; i < NENTRIES; i++) begin
      wsel[i]  = wr_en && (wr_addr == i[AW-1:0]);
      vld_d[i] = wsel[i] ? wr_valid : vld_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NENTRIES; i++) begin
      if (wsel[i]) begin
        key_q[i] <= wr_key;
        msk_q[i] <= wr_mask;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NENTRIES; g++) begin : g_cmp
      assign match[g] = vld_q[g] && (key_q[g] == lk_key);
    end
  endgenerate

  // lowest matching address wins
  always_comb begin
    lk_hit  = 1'b0;
    lk_mask = '0;
    for (int i = NENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        lk_hit  = 1'b1;
        lk_mask = msk_q[i];
      end
    end
  end

endmodule

// File: rtl/mcast_snoop_classifier.sv
module mcast_snoop_classifier
  import snoop_pkg::*;
#(
  parameter int NPORTS   = 8,
  parameter int NENTRIES = 16,
  localparam int PW      = $clog2(NPORTS),
  localparam int AW      = $clog2(NENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sof,
  input  logic [7:0]           in_data,
  input  logic [PW-1:0]        in_port,
  input  logic                 tbl_we,
  input  logic [AW-1:0]        tbl_addr,
  input  logic                 tbl_valid,
  input  logic [GRP_KEY_W-1:0] tbl_sfx,
  input  logic [NPORTS-1:0]    tbl_mask,
  output logic                 dec_valid,
  output logic [NPORTS-1:0]    dec_ports,
  output logic                 dec_cpu
);

  logic                 stb_q;
  frame_cls_e           cls_q;
  logic [GRP_KEY_W-1:0] key_q;
  logic [PW-1:0]        ing_port_q;
  logic                 hit;
  logic [NPORTS-1:0]    hit_mask, others;

  snoop_hdr_parser #(.PW(PW)) u_parse (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .in_data  (in_data),
    .in_port  (in_port),
    .stb_q    (stb_q),
    .cls_q    (cls_q),
    .key_q    (key_q),
    .ing_q    (ing_port_q)
  );

  snoop_grp_table #(.NENTRIES(NENTRIES), .NPORTS(NPORTS)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_we),
    .wr_addr  (tbl_addr),
    .wr_valid (tbl_valid),
    .wr_key   (tbl_sfx),
    .wr_mask  (tbl_mask),
    .lk_key   (key_q),
    .lk_hit   (hit),
    .lk_mask  (hit_mask)
  );

  always_comb begin
    others    = ~({{(NPORTS-1){1'b0}}, 1'b1} << ing_port_q);
    dec_valid = stb_q;
    dec_cpu   = 1'b0;
    dec_ports = '0;
    if (stb_q) begin
      case (cls_q)
        CLS_CTRL: dec_cpu   = 1'b1;
        CLS_DATA: dec_ports = hit ? (hit_mask & others) : others;
        default:  dec_ports = others;
      endcase
    end
  end

endmodule

// File: rtl/snoop_chk.sv
module snoop_chk #(
  parameter int NPORTS = 8,
  parameter int PW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_sof,
  input logic              dec_valid,
  input logic [NPORTS-1:0] dec_ports,
  input logic              dec_cpu,
  input logic [PW-1:0]     ing
);

  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  seen_q <= 1'b0;
    else if (in_valid && in_sof) seen_q <= 1'b0;
    else if (dec_valid)          seen_q <= 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |-> !dec_valid);

  assert_igmp_cpu_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_cpu) |-> (dec_ports == '0));

  assert_one_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  assert_once_per_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> !seen_q);

  assert_ingress_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> !dec_ports[ing]);

  assert_after_byte_R13: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid));

endmodule

bind mcast_snoop_classifier snoop_chk #(.NPORTS(NPORTS), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sof    (in_sof),
  .dec_valid (dec_valid),
  .dec_ports (dec_ports),
  .dec_cpu   (dec_cpu),
  .ing       (ing_port_q)
);

// File: tb/sim_mcast_snoop_classifier.sv
module sim_mcast_snoop_classifier;

  localparam int NP = 8;
  localparam int PW = 3;
  localparam int AW = 4;
  localparam int NV = 13;

  // {dst48, etype16, verhl8, proto8, ing3, ports8, cpu1, decide_idx5}
  localparam logic [96:0] VEC [NV] = '{
    {48'h001122334455, 16'h0800, 8'h45, 8'h11, 3'd2, 8'hFB, 1'b0, 5'd5},
    {48'hFFFFFFFFFFFF, 16'h0800, 8'h45, 8'h11, 3'd0, 8'hFE, 1'b0, 5'd5},
    {48'h01005E010101, 16'h0800, 8'h45, 8'h02, 3'd1, 8'h00, 1'b1, 5'd23},
    {48'h01005E010101, 16'h0800, 8'h45, 8'h11, 3'd1, 8'h0D, 1'b0, 5'd23},
    {48'h01005E7F0203, 16'h0800, 8'h45, 8'h11, 3'd7, 8'h20, 1'b0, 5'd23},
    {48'h01005E0A0B0C, 16'h0800, 8'h45, 8'h11, 3'd4, 8'hEF, 1'b0, 5'd23},
    {48'h01005E010101, 16'h86DD, 8'h60, 8'h02, 3'd0, 8'h0E, 1'b0, 5'd13},
    {48'h01005E010101, 16'h0800, 8'h44, 8'h02, 3'd3, 8'h07, 1'b0, 5'd23},
    {48'h01005E810101, 16'h0800, 8'h45, 8'h02, 3'd0, 8'hFE, 1'b0, 5'd5},
    {48'h01005E7F0203, 16'h0800, 8'h46, 8'h02, 3'd5, 8'h00, 1'b1, 5'd23},
    {48'h01005E010101, 16'h0800, 8'h65, 8'h02, 3'd2, 8'h0B, 1'b0, 5'd23},
    {48'h01005E7F0203, 16'h0806, 8'h45, 8'h02, 3'd5, 8'h80, 1'b0, 5'd13},
    {48'h333300000001, 16'h0800, 8'h45, 8'h11, 3'd6, 8'hBF, 1'b0, 5'd5}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_sof;
  logic [7:0]    in_data;
  logic [PW-1:0] in_port;
  logic          tbl_we, tbl_valid;
  logic [AW-1:0] tbl_addr;
  logic [22:0]   tbl_sfx;
  logic [NP-1:0] tbl_mask;
  logic          dec_valid, dec_cpu;
  logic [NP-1:0] dec_ports;

  int n_chk = 0;
  int n_bad = 0;
  int np, pidx;
  logic [7:0] pp;
  logic pc;

  always #4 clk = ~clk;

  mcast_snoop_classifier u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .in_port(in_port), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_valid(tbl_valid), .tbl_sfx(tbl_sfx), .tbl_mask(tbl_mask),
    .dec_valid(dec_valid), .dec_ports(dec_ports), .dec_cpu(dec_cpu)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string vtag(input int v);
    case (v)
      0, 1, 12: return "R2";
      2, 9:     return "R4";
      3:        return "R7/R12";
      4:        return "R10";
      5:        return "R8";
      6, 11:    return "R5";
      7, 10:    return "R6";
      default:  return "R3";
    endcase
  endfunction

  task automatic tbl_wr(input int a, input bit v, input logic [22:0] k, input logic [7:0] m);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = a[AW-1:0]; tbl_valid = v; tbl_sfx = k; tbl_mask = m;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic sample(input int i);
    if (dec_valid) begin
      np++;
      pidx = i;
      pp = dec_ports;
      pc = dec_cpu;
    end
  endtask

  function automatic logic [7:0] hdr_byte(input int i, input logic [47:0] da,
      input logic [15:0] et, input logic [7:0] vh, input logic [7:0] pr, input logic [PW-1:0] ing);
    if (i < 6)   return da[47-8*i -: 8];
    if (i == 11) return {5'd0, ing};
    if (i < 11)  return (i == 6) ? 8'h02 : 8'h00;
    if (i == 12) return et[15:8];
    if (i == 13) return et[7:0];
    if (i == 14) return vh;
    if (i == 23) return pr;
    return 8'(i);
  endfunction

  task automatic send(input logic [47:0] da, input logic [15:0] et, input logic [7:0] vh,
      input logic [7:0] pr, input logic [PW-1:0] ing, input int gap, input int nbytes);
    np = 0; pidx = -1; pp = '0; pc = 1'b0;
    for (int i = 0; i < nbytes; i++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); in_valid = 1'b0; in_sof = 1'b0;
        @(posedge clk); #1 sample(i - 1);
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_port  = (i == 0) ? ing : ~ing;
      in_data  = hdr_byte(i, da, et, vh, pr, ing);
      @(posedge clk); #1 sample(i);
    end
    for (int t = 0; t < 3; t++) begin
      @(negedge clk); in_valid = 1'b0; in_sof = 1'b0;
      @(posedge clk); #1 sample(nbytes - 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_data = '0; in_port = '0;
    tbl_we = 1'b0; tbl_addr = '0; tbl_valid = 1'b0; tbl_sfx = '0; tbl_mask = '0;
    repeat (3) @(negedge clk);
    chk("R1 dec_valid in reset", int'(dec_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dec_valid after reset", int'(dec_valid), 0);

    // R1: empty table floods data
    send(48'h01005E010101, 16'h0800, 8'h45, 8'h11, 3'd1, 0, 30);
    chk("R1 pulses", np, 1);
    chk("R1 ports", int'(pp), 'hFD);

    tbl_wr(0, 1'b1, 23'h010101, 8'h0F);
    tbl_wr(3, 1'b1, 23'h7F0203, 8'hA0);
    tbl_wr(5, 1'b1, 23'h7F0203, 8'h0C);

    for (int v = 0; v < NV; v++) begin
      send(VEC[v][96:49], VEC[v][48:33], VEC[v][32:25], VEC[v][24:17], VEC[v][16:14], 0, 30);
      chk({vtag(v), " R11 pulse count"}, np, 1);
      chk({vtag(v), " decision byte"}, pidx, int'(VEC[v][4:0]));
      chk({vtag(v), " ports"}, int'(pp), int'(VEC[v][13:6]));
      chk({vtag(v), " cpu"}, int'(pc), int'(VEC[v][5]));
    end

    // R13: idle cycles between bytes
    send(48'h01005E010101, 16'h0800, 8'h45, 8'h02, 3'd2, 2, 26);
    chk("R13 pulse count", np, 1);
    chk("R13 decision byte", pidx, 23);
    chk("R13 cpu", int'(pc), 1);

    // R9: remove entry, then rewrite and use at once
    tbl_wr(0, 1'b0, 23'h010101, 8'h0F);
    send(48'h01005E010101, 16'h0800, 8'h45, 8'h11, 3'd1, 0, 24);
    chk("R9 cleared entry floods", int'(pp), 'hFD);
    tbl_wr(0, 1'b1, 23'h010101, 8'h30);
    send(48'h01005E010101, 16'h0800, 8'h45, 8'h11, 3'd1, 0, 24);
    chk("R9 new mask", int'(pp), 'h30);

    // R11: truncated frame yields nothing, the restart yields one
    send(48'h01005E010101, 16'h0800, 8'h45, 8'h11, 3'd1, 0, 10);
    chk("R11 truncated frame pulses", np, 0);
    send(48'h01005E010101, 16'h0800, 8'h45, 8'h11, 3'd4, 0, 24);
    chk("R11 restarted frame pulses", np, 1);
    chk("R12 restarted ports", int'(pp), 'h20);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule